// File: doc/BRIEF.md
# UART Receive FIFO with Per-Entry Error Word

This block sits behind a UART deserialiser and buffers what it delivers. Each delivered byte arrives together with its parity, framing and break flags. The block stores the byte and a 4-bit error word as one entry of a 16-deep first-in first-out queue.

Software sees the head entry's error word and data byte at all times. It reads the error word first, then pulses the data read, which removes the entry. A status word gives the fill level. Two interrupt sources are reported through write-one-to-clear bits:
- a fill-level trigger with four selectable thresholds;
- an idle-line timeout counted in bit times from a baud strobe.

Clearing the receive enable empties the queue and restarts the receive-side state.

Top module: `uart_rx_fifo`

## Requirements
- R1: Each stored entry holds the data byte and an error word whose bit 0 is overrun, bit 1 parity error, bit 2 frame error and bit 3 break detect; `rd_data`/`rd_err` always show the oldest entry, and entries leave in arrival order.
- R2: A `data_rd` pulse removes the head entry at that clock edge; a `data_rd` pulse while empty changes nothing.
- R3: `fifo_stat` bits 3:0 carry the entry count modulo 16, bit 8 is set exactly when 16 entries are held, and all other bits are zero.
- R4: A byte arriving while 16 entries are held (and no flush occurs) is discarded. The next byte that is stored gets overrun (error bit 0) set. Later entries do not carry it.
- R5: `int_stat[0]` (trigger) becomes set on the clock edge after the count is at or above (`trig_sel`+1)*4, i.e. 4, 8, 12 or 16. It cannot be cleared while the count remains at or above that level.
- R6: With `rx_en` and `tout_en` high, `int_stat[1]` (timeout) becomes set on the edge of the 32nd `bit_tick` since the last byte arrival, even when the queue is empty. It fires only once per idle stretch and never fires while `tout_en` is low.
- R7: Writing ones on `int_clr` clears the matching `int_stat` bits. A set event in the same cycle wins. `irq` is the OR of the `int_stat` bits.
- R8: While `rx_en` is low the queue is emptied, pending overrun and the idle count are cleared, and arriving bytes are ignored.
- R9: A `fifo_rst` pulse empties the queue at that edge and clears any pending overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low flushes |
| fifo_rst | input | 1 | Queue flush pulse |
| tout_en | input | 1 | Timeout interrupt enable |
| trig_sel | input | 2 | Trigger level select (4,8,12,16) |
| bit_tick | input | 1 | One pulse per bit time |
| in_valid | input | 1 | Byte delivered by deserialiser |
| in_data | input | 8 | Delivered byte |
| in_parity_err | input | 1 | Parity error for the byte |
| in_frame_err | input | 1 | Frame error for the byte |
| in_break | input | 1 | Break detected for the byte |
| data_rd | input | 1 | Read data and remove head entry |
| rd_data | output | 8 | Head entry data |
| rd_err | output | 4 | Head entry error word |
| fifo_stat | output | 9 | Count in 3:0, full in bit 8 |
| int_clr | input | 2 | Write-one-to-clear for int_stat |
| int_stat | output | 2 | {timeout, trigger} interrupt status |
| irq | output | 1 | Any interrupt pending |

## Verification
A stored byte shows in `fifo_stat` and at the head one edge after `in_valid` is sampled, and a pop shows one edge after `data_rd`. The trigger bit follows one edge later than the count. The timeout bit rises on the same edge as the 32nd strobe. The bench drives every input on the falling edge and reads every result just before the next falling edge, so each check lands in exactly the cycle given here. The trigger is checked both on the cycle where the count first reaches the level (still clear) and on the following cycle (set).

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH     = 16,
  parameter int TOUT_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       fifo_rst,
  input  logic       tout_en,
  input  logic [1:0] trig_sel,
  input  logic       bit_tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_parity_err,
  input  logic       in_frame_err,
  input  logic       in_break,
  input  logic       data_rd,
  output logic [7:0] rd_data,
  output logic [3:0] rd_err,
  output logic [8:0] fifo_stat,
  input  logic [1:0] int_clr,
  output logic [1:0] int_stat,
  output logic       irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int TW  = $clog2(TOUT_BITS + 1);
  localparam int QTR = DEPTH / 4;

  logic [11:0]   mem [DEPTH];
  logic [AW:0]   wp, rp, cnt, lvl;
  logic          full, empty, push, drop, pop, flush, ovr_pend;
  logic [TW-1:0] idle;
  logic          int_trig, int_tout, tout_evt;

  assign cnt   = wp - rp;
  assign full  = cnt == (AW+1)'(DEPTH);
  assign empty = cnt == '0;
  assign flush = !rx_en || fifo_rst;
  assign push  = rx_en && in_valid && !full;
  assign drop  = rx_en && in_valid && full;
  assign pop   = rx_en && data_rd && !empty;
  assign lvl   = (AW+1)'((int'(trig_sel) + 1) * QTR);

  assign rd_data   = mem[rp[AW-1:0]][7:0];
  assign rd_err    = mem[rp[AW-1:0]][11:8];
  assign fifo_stat = {full, (8-AW)'(0), cnt[AW-1:0]};
  assign int_stat  = {int_tout, int_trig};
  assign irq       = int_tout | int_trig;

  always_ff @(posedge clk)
    if (push && !fifo_rst)
      mem[wp[AW-1:0]] <= {in_break, in_frame_err, in_parity_err, ovr_pend, in_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; ovr_pend <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; ovr_pend <= 1'b0;
    end else begin
      if (push) begin
        wp <= wp + 1'b1;
        ovr_pend <= 1'b0;
      end
      if (drop) ovr_pend <= 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end

  assign tout_evt = rx_en && tout_en && !in_valid && bit_tick && idle == TW'(TOUT_BITS - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idle <= '0;
    else if (!rx_en || !tout_en || in_valid) idle <= '0;
    else if (bit_tick && idle != TW'(TOUT_BITS)) idle <= idle + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      int_trig <= 1'b0; int_tout <= 1'b0;
    end else begin
      int_trig <= (rx_en && cnt >= lvl) | (int_trig & ~int_clr[0]);
      int_tout <= tout_evt | (int_tout & ~int_clr[1]);
    end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= (AW+1)'(DEPTH));
  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && empty && data_rd && !in_valid |=> empty);
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && full && in_valid && !data_rd && !fifo_rst |=> full);
  // R8
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> empty);
  // R6
  tout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_tout && !tout_en |=> !int_tout);
endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, fifo_rst = 0, tout_en = 0, bit_tick = 0, in_valid = 0;
  logic in_parity_err = 0, in_frame_err = 0, in_break = 0, data_rd = 0;
  logic [1:0] trig_sel = 0, int_clr = 0, int_stat;
  logic [7:0] in_data = 0, rd_data;
  logic [3:0] rd_err;
  logic [8:0] fifo_stat;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_fifo i_uart_rx_fifo (.*);

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic [2:0] f);
    in_valid = 1; in_data = d;
    {in_break, in_frame_err, in_parity_err} = f;
    cyc();
    in_valid = 0; {in_break, in_frame_err, in_parity_err} = 0;
  endtask

  task automatic pop();
    data_rd = 1; cyc(); data_rd = 0;
  endtask

  task automatic flush_clr();
    fifo_rst = 1; cyc(); fifo_rst = 0;
    int_clr = 2'b11; cyc(); int_clr = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin bit_tick = 1; cyc(); end
    bit_tick = 0;
  endtask

  function automatic logic [8:0] stat_of(int n);
    return {n == 16, 4'b0, 4'(n)};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(2); rst_n = 1; cyc();
    chk(fifo_stat == 0 && int_stat == 0 && !irq, "R3 reset", fifo_stat, 0);
    push(8'h11, 0); cyc();
    chk(fifo_stat == 0, "R8 ignored while disabled", fifo_stat, 0);
    rx_en = 1; cyc();

    // R1 R3 R4: fill, overflow, overrun tagging
    for (int i = 0; i < 16; i++) begin
      push(8'(i * 7 + 3), 3'(i % 8));
      chk(fifo_stat == stat_of(i + 1), "R3 count", fifo_stat, stat_of(i + 1));
    end
    push(8'hEE, 3'b111);
    chk(fifo_stat == stat_of(16), "R4 drop when full", fifo_stat, stat_of(16));
    chk(rd_data == 8'd3 && rd_err == 4'h0, "R1 head", {rd_err, rd_data}, 12'h003);
    pop();
    push(8'hA5, 3'b000);
    chk(fifo_stat == stat_of(16), "R4 refill", fifo_stat, stat_of(16));
    for (int i = 1; i < 16; i++) begin
      chk(rd_data == 8'(i * 7 + 3) && rd_err == {1'(i % 8 >> 2), 1'(i % 8 >> 1), 1'(i % 8), 1'b0},
          "R1 order/err", {rd_err, rd_data}, {1'(i % 8 >> 2), 1'(i % 8 >> 1), 1'(i % 8), 1'b0, 8'(i * 7 + 3)});
      pop();
      chk(fifo_stat == stat_of(16 - i), "R2 pop count", fifo_stat, stat_of(16 - i));
    end
    chk(rd_data == 8'hA5 && rd_err == 4'h1, "R4 overrun on next entry", {rd_err, rd_data}, 12'h1A5);
    pop();
    push(8'h5A, 3'b010);
    chk(rd_err == 4'h4 && rd_data == 8'h5A, "R4 overrun only once", {rd_err, rd_data}, 12'h45A);
    pop();
    pop();
    chk(fifo_stat == 0, "R2 pop on empty", fifo_stat, 0);
    push(8'h77, 0);
    chk(rd_data == 8'h77 && fifo_stat == stat_of(1), "R2 pointers intact", rd_data, 8'h77);

    // R9 / R8 flush
    push(8'h01, 0); push(8'h02, 0);
    fifo_rst = 1; cyc(); fifo_rst = 0;
    chk(fifo_stat == 0, "R9 fifo_rst", fifo_stat, 0);
    for (int i = 0; i < 16; i++) push(8'(i), 0);
    push(8'hFF, 0);
    rx_en = 0; cyc(); rx_en = 1;
    chk(fifo_stat == 0, "R8 disable flush", fifo_stat, 0);
    push(8'h33, 0);
    chk(rd_err == 4'h0, "R8 overrun pending cleared", rd_err, 0);

    // R5 R7 trigger sweep
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      flush_clr();
      for (int k = 0; k < (s + 1) * 4 - 1; k++) push(8'(k), 0);
      cyc();
      chk(int_stat[0] == 0, "R5 below level", int_stat, 0);
      push(8'hC0, 0);
      chk(int_stat[0] == 0, "R5 one-cycle lag", int_stat, 0);
      cyc();
      chk(int_stat[0] == 1 && irq, "R5 at level", int_stat, 1);
      int_clr = 2'b01; cyc(); int_clr = 0;
      chk(int_stat[0] == 1, "R7 set wins over clear", int_stat, 1);
      pop(); cyc();
      int_clr = 2'b01; cyc(); int_clr = 0;
      chk(int_stat[0] == 0 && !irq, "R7 w1c trigger", int_stat, 0);
    end
    trig_sel = 2'd3;

    // R6 R7 timeout
    flush_clr();
    tout_en = 1; cyc();
    ticks(31);
    chk(int_stat[1] == 0, "R6 31 ticks", int_stat, 0);
    ticks(1);
    chk(int_stat[1] == 1 && fifo_stat == 0, "R6 fires on empty", int_stat, 2);
    ticks(40);
    int_clr = 2'b10; cyc(); int_clr = 0;
    ticks(10);
    chk(int_stat[1] == 0, "R7 w1c / R6 once per idle", int_stat, 0);
    push(8'h44, 0);
    ticks(31);
    chk(int_stat[1] == 0, "R6 restart after byte", int_stat, 0);
    ticks(1);
    chk(int_stat[1] == 1 && fifo_stat == stat_of(1), "R6 fires with data", int_stat, 2);
    int_clr = 2'b10; tout_en = 0; cyc(); int_clr = 0;
    ticks(40);
    chk(int_stat[1] == 0, "R6 disabled", int_stat, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule